// File: doc/BRIEF.md
# Dual-mode per-processor counter/timer bank

This block holds one system counter channel and a parameter-sized set of processor channels, all sharing one register access port and a common count tick. Each processor channel works in one of two modes. In counter mode it counts ticks up to a programmed limit, wraps, latches a reached flag and raises its own interrupt line. In user-timer mode the same register offsets expose a 63-bit up-counter as a high and a low 32-bit word. Software can start and stop it, and it never interrupts.

A mode register, reachable only through the system channel, holds one bit per processor channel. Changing a bit has defined side effects. Entering user mode drops the interrupt, clears the count and leaves the channel stopped if its run bit is clear. Leaving user mode restarts the channel as a counter. Counts move in units of bit 9, so bits 8:0 of every count word read zero. A read returns data in `rdata_o` one clock after `rd_i`.

Top module: `tmr_bank`

## Requirements
- R1: After reset the mode register reads 0, every channel is a free-running counter with limit 0, count 0 and reached clear, every proc channel's run bit (offset 0xC, bit 0) reads 1, and all interrupt lines are low.
- R2: In counter mode each tick advances the count (offset 0x4, bits 30:9) by one. When the next value would equal the limit (bits 30:9), the count returns to 0, the reached flag (offset 0x4 bit 31) sets and the channel's interrupt asserts. A limit of 0 free-runs with no reached flag and no interrupt.
- R3: In counter mode, a write to offset 0x0 sets the limit, zeroes the count and drops the interrupt. A write to offset 0x8 sets the limit and keeps the count. A read of offset 0x0 returns the limit and clears both the reached flag and the interrupt. A write to offset 0x4 has no effect.
- R4: The mode register is at offset 0x10. It can be read from any channel and written only through channel 0. Bit i controls proc channel i+1. Writes from other channels are ignored, and bits at or above N_PROC read 0.
- R5: In user mode, offset 0x0 reads {reached, count[62:32]} and offset 0x4 reads count[31:9] with bits 8:0 zero. While running, each tick adds one unit of bit 9.
- R6: In user mode, writing offset 0x0 loads count[62:32] from bits 30:0, and writing offset 0x4 loads count[31:9]. The other half is kept and the reached flag clears.
- R7: In user mode, writing offset 0xC bit 0 starts (1) or stops (0) the count. Offset 0xC reads the run bit on proc channels and 0 on channel 0.
- R8: A channel in user mode never asserts its interrupt.
- R9: Switching a channel from counter to user mode drops its interrupt and zeroes its count. The channel stays stopped if its run bit is clear.
- R10: Switching a channel from user to counter mode sets its run bit to 1 and zeroes its count. The channel then counts as a counter with its stored limit.
- R11: A user count stops at 0x7FFFFFFF_FFFFFE00. A tick at that value sets the reached flag and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable pulse, one count unit |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| chan_i | input | $clog2(N_PROC+1) | Channel select, 0 = system channel |
| off_i | input | 3 | Word offset (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_i |
| irq_o | output | N_PROC+1 | Per-channel interrupt, bit 0 = system channel |

## Verification
The properties assume that the bus carries at most one access per cycle, so a mode change and a write to the same processor channel never meet in one cycle. The bench always drives `wr_i` and `rd_i` in separate cycles and leaves an idle cycle between accesses. Ticks are issued only between accesses. As a result, the ordering of a read-clear against a limit match in the same cycle is never stressed. A behavioural model in the bench predicts every interrupt line on every clock and every read word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int UNIT_SH = 9;                    // count unit is bit 9
  localparam int LO_W = DATA_W - UNIT_SH;        // user low word count bits
  localparam int HI_W = DATA_W - 1;              // user high word count bits
  localparam int PER_W = HI_W + LO_W;            // user count in units
  localparam int LIM_W = DATA_W - 1 - UNIT_SH;   // counter-mode width in units

  localparam logic [2:0] OFF_HI   = 3'd0;
  localparam logic [2:0] OFF_LO   = 3'd1;
  localparam logic [2:0] OFF_LNR  = 3'd2;
  localparam logic [2:0] OFF_RUN  = 3'd3;
  localparam logic [2:0] OFF_MODE = 3'd4;
endpackage

// File: rtl/tmr_mode.sv
module tmr_mode
  import tmr_pkg::*;
#(
  parameter int N_PROC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [N_PROC-1:0] wdata_i,
  output logic [N_PROC-1:0] mode_o,
  output logic [N_PROC-1:0] to_user_o,
  output logic [N_PROC-1:0] to_cnt_o
);
  logic [N_PROC-1:0] mode_q;

  assign to_user_o = wr_i ? (wdata_i & ~mode_q) : '0;
  assign to_cnt_o  = wr_i ? (~wdata_i & mode_q) : '0;
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (wr_i) mode_q <= wdata_i;
  end

  a_r4_mode_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mode_o == $past(wdata_i)));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter bit IS_SYS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              user_i,
  input  logic              to_user_i,
  input  logic              to_cnt_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [LIM_W-1:0] lim_q, lim_d, eff_lim, inc_lo;
  logic reach_q, reach_d, irq_q, irq_d, run_q, run_d;
  logic wr_hi, ld_lo, mode_chg, do_tick, wrap, usr_sat, tick_hit, rd_clr, usr_clr;

  assign eff_lim  = (lim_q == '0) ? {LIM_W{1'b1}} : lim_q;
  assign inc_lo   = cnt_q[LIM_W-1:0] + 1'b1;
  assign wrap     = (inc_lo == eff_lim);
  assign usr_sat  = &cnt_q;
  assign wr_hi    = wr_i && (off_i == OFF_HI);
  assign ld_lo    = wr_i && (off_i == OFF_LO) && user_i;
  assign mode_chg = to_user_i || to_cnt_i;
  // counters always run; the run bit gates user mode only
  assign do_tick  = tick_i && (run_q || !user_i) && !wr_hi && !ld_lo && !mode_chg;
  assign tick_hit = do_tick && (user_i ? usr_sat : (wrap && (lim_q != '0)));
  assign rd_clr   = rd_i && (off_i == OFF_HI) && !user_i;
  assign usr_clr  = (wr_hi || ld_lo) && user_i;

  always_comb begin
    cnt_d = cnt_q;
    if (mode_chg)                cnt_d = '0;
    else if (wr_hi && user_i)    cnt_d = {wdata_i[HI_W-1:0], cnt_q[LO_W-1:0]};
    else if (wr_hi)              cnt_d = '0;
    else if (ld_lo)              cnt_d = {cnt_q[PER_W-1:LO_W], wdata_i[DATA_W-1:UNIT_SH]};
    else if (do_tick && user_i)  cnt_d = usr_sat ? cnt_q : cnt_q + 1'b1;
    else if (do_tick)            cnt_d = wrap ? '0 : {{(PER_W-LIM_W){1'b0}}, inc_lo};
  end

  always_comb begin
    lim_d = lim_q;
    if (wr_i && ((off_i == OFF_LNR) || ((off_i == OFF_HI) && !user_i)))
      lim_d = wdata_i[DATA_W-2:UNIT_SH];
  end

  always_comb begin
    run_d = run_q;
    if (to_cnt_i)                                   run_d = 1'b1;
    else if (!IS_SYS && wr_i && (off_i == OFF_RUN)) run_d = wdata_i[0];
  end

  always_comb begin
    reach_d = reach_q;
    if (tick_hit)               reach_d = 1'b1;
    else if (rd_clr || usr_clr) reach_d = 1'b0;
    irq_d = irq_q;
    if (tick_hit && !user_i)                                 irq_d = 1'b1;
    else if (rd_clr || to_user_i || (wr_hi && !user_i))      irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lim_q   <= '0;
      reach_q <= 1'b0;
      irq_q   <= 1'b0;
      run_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      reach_q <= reach_d;
      irq_q   <= irq_d;
      run_q   <= run_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (off_i)
      OFF_HI:  rdata_o = user_i ? {reach_q, cnt_q[PER_W-1:LO_W]}
                                : {1'b0, lim_q, {UNIT_SH{1'b0}}};
      OFF_LO:  rdata_o = user_i ? {cnt_q[LO_W-1:0], {UNIT_SH{1'b0}}}
                                : {reach_q, cnt_q[LIM_W-1:0], {UNIT_SH{1'b0}}};
      OFF_RUN: rdata_o = IS_SYS ? '0 : {{(DATA_W-1){1'b0}}, run_q};
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  a_r8_user_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_i |-> !irq_o);
  a_r9_enter_user_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_user_i |=> !irq_o);
  a_r10_leave_user_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_cnt_i |=> run_q);
  a_r7_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_i && !run_q && !wr_i && !mode_chg) |=> $stable(cnt_q));
  a_r11_saturated_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_i && usr_sat && !wr_i && !mode_chg) |=> (&cnt_q));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_PROC = 4,
  localparam int NCH  = N_PROC + 1,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [2:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    irq_o
);
  logic [N_PROC-1:0] mode_q, to_user, to_cnt;
  logic [NCH-1:0]    ch_sel;
  logic [DATA_W-1:0] ch_rd [NCH];
  logic [DATA_W-1:0] mode_ext, rdata_q;
  logic              mode_wr;

  assign mode_wr  = wr_i && (chan_i == '0) && (off_i == OFF_MODE);
  assign mode_ext = {{(DATA_W-N_PROC){1'b0}}, mode_q};

  tmr_mode #(.N_PROC(N_PROC)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (mode_wr),
    .wdata_i   (wdata_i[N_PROC-1:0]),
    .mode_o    (mode_q),
    .to_user_o (to_user),
    .to_cnt_o  (to_cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic usr, t_usr, t_cnt;
    assign ch_sel[g] = (int'(chan_i) == g);
    if (g == 0) begin : g_sys
      assign usr   = 1'b0;
      assign t_usr = 1'b0;
      assign t_cnt = 1'b0;
    end else begin : g_proc
      assign usr   = mode_q[g-1];
      assign t_usr = to_user[g-1];
      assign t_cnt = to_cnt[g-1];
    end
    tmr_chan #(.IS_SYS(g == 0)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .user_i    (usr),
      .to_user_i (t_usr),
      .to_cnt_i  (t_cnt),
      .wr_i      (wr_i && ch_sel[g]),
      .rd_i      (rd_i && ch_sel[g]),
      .off_i     (off_i),
      .wdata_i   (wdata_i),
      .rdata_o   (ch_rd[g]),
      .irq_o     (irq_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdata_q <= '0;
    else if (!rd_i)               rdata_q <= '0;
    else if (off_i == OFF_MODE)   rdata_q <= mode_ext;
    else if (int'(chan_i) < NCH)  rdata_q <= ch_rd[chan_i];
    else                          rdata_q <= '0;
  end
  assign rdata_o = rdata_q;

  a_r4_proc_mode_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (chan_i != '0) && (off_i == OFF_MODE)) |=> $stable(mode_q));
endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  localparam int NP = 4;
  localparam int NC = NP + 1;
  localparam longint unsigned PMAX = (64'd1 << 54) - 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0] chan = '0, off = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NC-1:0] irq;

  always #5 clk = ~clk;

  tmr_bank #(.N_PROC(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .rd_i(rd),
    .chan_i(chan), .off_i(off), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  longint unsigned m_cnt [NC];
  longint unsigned t_cnt [NC];
  int unsigned     m_lim [NC];
  bit m_rch [NC], m_irq [NC], m_run [NC], t_hit [NC], t_skip [NC];
  int unsigned m_mode;
  logic [31:0] m_rd;
  bit m_rdv;
  int errs = 0, checks = 0, cyc = 0;
  string req = "R1";

  function automatic bit is_user(int c);
    return c != 0 && ((m_mode >> (c - 1)) & 1) != 0;
  endfunction

  function automatic logic [31:0] m_read(int c, int o);
    if (o == 4) return m_mode;
    if (c >= NC) return 32'd0;
    case (o)
      0: return is_user(c) ? {m_rch[c], 31'(m_cnt[c] >> 23)} : (32'(m_lim[c]) << 9);
      1: return is_user(c) ? 32'(m_cnt[c] << 9) : {m_rch[c], 22'(m_cnt[c]), 9'd0};
      3: return c == 0 ? 32'd0 : {31'd0, m_run[c]};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_cnt[c] = 0; m_lim[c] = 0; m_rch[c] = 0; m_irq[c] = 0; m_run[c] = 1;
      end
      m_mode = 0; m_rdv = 0; m_rd = 0;
    end else begin
      m_rdv = rd;
      if (rd) m_rd = m_read(int'(chan), int'(off));
      for (int c = 0; c < NC; c++) t_skip[c] = 0;
      if (wr && int'(chan) < NC && (off == 0 || (off == 1 && is_user(int'(chan)))))
        t_skip[chan] = 1;
      if (wr && chan == 0 && off == 4)
        for (int i = 0; i < NP; i++)
          if (((wdata >> i) & 1) != ((m_mode >> i) & 1)) t_skip[i+1] = 1;
      // tick from the pre-edge state
      for (int c = 0; c < NC; c++) begin
        t_hit[c] = 0; t_cnt[c] = m_cnt[c];
        if (tick && !t_skip[c]) begin
          if (is_user(c)) begin
            if (m_run[c]) begin
              if (m_cnt[c] == PMAX) t_hit[c] = 1;
              else t_cnt[c] = m_cnt[c] + 1;
            end
          end else begin
            longint unsigned nx, el;
            nx = (m_cnt[c] + 1) & 64'h3FFFFF;
            el = (m_lim[c] == 0) ? 64'h3FFFFF : 64'(m_lim[c]);
            if (nx == el) begin t_cnt[c] = 0; t_hit[c] = (m_lim[c] != 0); end
            else t_cnt[c] = nx;
          end
        end
      end
      for (int c = 0; c < NC; c++) m_cnt[c] = t_cnt[c];
      if (wr && int'(chan) < NC) begin
        int c;
        c = int'(chan);
        case (int'(off))
          0: if (is_user(c)) begin
               m_cnt[c] = (m_cnt[c] & 64'h7FFFFF) | (64'(wdata & 32'h7FFFFFFF) << 23);
               m_rch[c] = 0;
             end else begin
               m_lim[c] = (wdata >> 9) & 32'h3FFFFF; m_cnt[c] = 0; m_irq[c] = 0;
             end
          1: if (is_user(c)) begin
               m_cnt[c] = (m_cnt[c] & ~64'h7FFFFF) | 64'(wdata >> 9);
               m_rch[c] = 0;
             end
          2: m_lim[c] = (wdata >> 9) & 32'h3FFFFF;
          3: if (c != 0) m_run[c] = wdata[0];
          4: if (c == 0) begin
               for (int i = 0; i < NP; i++) begin
                 if (((wdata >> i) & 1) != ((m_mode >> i) & 1)) begin
                   m_cnt[i+1] = 0;
                   if (wdata[i]) m_irq[i+1] = 0;
                   else m_run[i+1] = 1;
                 end
               end
               m_mode = wdata & ((32'd1 << NP) - 1);
             end
          default: ;
        endcase
      end
      if (rd && int'(chan) < NC && off == 0 && !is_user(int'(chan))) begin
        m_rch[chan] = 0; m_irq[chan] = 0;
      end
      for (int c = 0; c < NC; c++)
        if (t_hit[c]) begin
          m_rch[c] = 1;
          if (!is_user(c)) m_irq[c] = 1;
        end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++) chk($sformatf("irq[%0d]", c), 32'(irq[c]), 32'(m_irq[c]));
      if (m_rdv) chk("rdata", rdata, m_rd);
    end
  end

  task automatic bus_wr(int c, int o, logic [31:0] d);
    @(negedge clk); wr = 1; rd = 0; chan = 3'(c); off = 3'(o); wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(int c, int o);
    @(negedge clk); rd = 1; wr = 0; chan = 3'(c); off = 3'(o);
    @(negedge clk); rd = 0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    req = "R1";
    bus_rd(1, 3); bus_rd(0, 3); bus_rd(1, 0); bus_rd(1, 1); bus_rd(0, 4);
    // R2 limit match on channel 0, free run on channel 1
    req = "R2";
    bus_wr(0, 0, 32'h600);
    for (int k = 0; k < 4; k++) begin ticks(1); bus_rd(0, 1); bus_rd(1, 1); end
    // R3 limit read clears, no-reset limit, ignored count write
    req = "R3";
    bus_rd(0, 0); bus_rd(0, 1);
    ticks(1); bus_wr(0, 2, 32'hA00); ticks(2); bus_rd(0, 1);
    bus_wr(0, 1, 32'h0001_2400); bus_rd(0, 1);
    bus_wr(3, 0, 32'h400); ticks(3); bus_rd(3, 1);
    // R4 mode access rules
    req = "R4";
    bus_wr(1, 4, 32'hF); bus_rd(0, 4); bus_rd(2, 4);
    bus_wr(0, 4, 32'hF0); bus_rd(3, 4);
    // R9 entering user mode; ch2 stopped beforehand
    req = "R9";
    bus_wr(2, 3, 32'h0);
    bus_wr(0, 4, 32'hF); bus_rd(1, 4);
    ticks(3); bus_rd(2, 1); bus_rd(1, 1); bus_rd(3, 0);
    // R5 / R6 split access
    req = "R5";
    bus_wr(1, 0, 32'h1234_5678); bus_rd(1, 0); bus_rd(1, 1);
    req = "R6";
    bus_wr(1, 1, 32'hABCD_E000); bus_rd(1, 0); bus_rd(1, 1);
    ticks(1); bus_rd(1, 1);
    // R7 run control
    req = "R7";
    bus_wr(1, 3, 32'h0); ticks(3); bus_rd(1, 1); bus_rd(1, 3);
    bus_wr(1, 3, 32'h1); ticks(2); bus_rd(1, 1); bus_rd(0, 3);
    // R8 user channels stay quiet while ticking
    req = "R8";
    bus_wr(4, 2, 32'h400); ticks(5); bus_rd(4, 1); bus_rd(4, 0);
    // R11 saturation
    req = "R11";
    bus_wr(1, 0, 32'h7FFF_FFFF); bus_wr(1, 1, 32'hFFFF_FC00);
    ticks(1); bus_rd(1, 1); ticks(2); bus_rd(1, 0); bus_rd(1, 1);
    req = "R6";
    bus_wr(1, 1, 32'h0); bus_rd(1, 0);
    // R10 back to counter mode
    req = "R10";
    bus_wr(0, 4, 32'h0); bus_rd(2, 3); bus_rd(2, 1); bus_rd(4, 1);
    ticks(3); bus_rd(2, 1); bus_rd(4, 1); bus_rd(4, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule